// File: doc/BRIEF.md
# Per-Pin Interrupt and Wake Event Detector

This block turns the already-filtered level of each general-purpose input into interrupt and wake events. Each pin carries its own trigger configuration: level or edge sensing, and a polarity selection that can also ask for both edges. When the programmed condition is met, the pin sets a sticky interrupt-status bit and, if waking is allowed in the current sleep state, a sticky wake-status bit. Software clears either bit by pulsing a write-one-to-clear strobe.

Generating status and forwarding it are controlled separately. An enable bit lets interrupt status be recorded at all. A mask bit, where 1 means unmasked, decides whether a pending pin raises its request line. A global blocking window, opened by the surrounding logic after any debounce reconfiguration, suppresses all new status on every pin. While it is open, the enable readback shows 0.

All outputs are registered. An input condition that is present before a rising clock edge is visible on the outputs just after that edge. A bank of `NUM_PINS` identical, independent pin slices shares only the sleep-state and blocking-window inputs.

Top module: `pin_evt_bank`

## Requirements
- R1: While reset is high, and on the first edge after it, every output is 0. The stored previous input sample is also 0, so a pin that is high at release reads as a rising edge.
- R2: With `trig_level`=0 (edge sensing), polarity code 2'b00 sets interrupt status on a rising edge of the input and code 2'b01 sets it on a falling edge. An edge is the difference between the current level and the level registered on the previous clock.
- R3: Polarity code 2'b10 sets status on either edge, but only under edge sensing. Under level sensing, codes 2'b10 and 2'b11 never set status, and code 2'b11 never sets it under edge sensing either.
- R4: With `trig_level`=1, code 2'b00 sets status while the input is high and code 2'b01 sets it while the input is low. After a clear, status is set again on the next cycle if the active level is still present.
- R5: A 1 on `clr_int` clears that pin's interrupt status on the next edge. The clear wins over a trigger in the same cycle.
- R6: While `irq_en` is 0, no interrupt status is set. An edge that happened while it was 0 is not recorded and does not appear when it returns to 1.
- R7: Wake status is set by a trigger when the wake-enable bit for the present sleep state is 1. The sleep-state code 2'b01 (light idle) selects wake-enable bit 0, 2'b10 (suspend to RAM) selects bit 1 and 2'b11 (hibernate or off) selects bit 2. The code 2'b00 (running) never sets wake status. Wake status does not depend on `irq_en`.
- R8: A 1 on `clr_wake` clears that pin's wake status on the next edge, winning over a coincident trigger.
- R9: `pending` is the OR of interrupt and wake status. `irq_req` is `pending` qualified by `irq_en`, by `irq_unmask` and by the blocking window being closed.
- R10: While `block_win` is 1, no new interrupt or wake status is set on any pin, `irq_req` stays 0 and `en_readback` reads 0.
- R11: Pins are independent: one pin's stimulus or clear leaves the other pins' status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| level_in | input | NUM_PINS | Filtered pin levels |
| trig_level | input | NUM_PINS | 1 selects level sensing, 0 edge sensing |
| pol_sel | input | 2*NUM_PINS | Polarity code per pin: 00 high/rising, 01 low/falling, 10 both edges |
| irq_en | input | NUM_PINS | Interrupt status generation enable |
| irq_unmask | input | NUM_PINS | 1 forwards pending status as a request |
| wake_en | input | 3*NUM_PINS | Per pin: bit 0 light idle, bit 1 suspend to RAM, bit 2 hibernate |
| sleep_state | input | 2 | 00 running, 01 light idle, 10 suspend to RAM, 11 hibernate |
| block_win | input | 1 | Global status-blocking window |
| clr_int | input | NUM_PINS | Write-one-to-clear strobe for interrupt status |
| clr_wake | input | NUM_PINS | Write-one-to-clear strobe for wake status |
| int_sts | output | NUM_PINS | Sticky interrupt status |
| wake_sts | output | NUM_PINS | Sticky wake status |
| pending | output | NUM_PINS | Interrupt or wake status set |
| irq_req | output | NUM_PINS | Qualified request |
| en_readback | output | NUM_PINS | Enable as seen by software, 0 during blocking |

## Verification
The properties assume that every input is stable around the rising edge and that the strobes, `block_win` and `sleep_state` are plain levels sampled once per clock. They relate each output to the inputs of the previous cycle only. The bench therefore changes inputs on the falling edge and holds them for a whole cycle. It keeps `sleep_state` at a single legal code for each step and never leans on any ordering inside one edge. Stimulus that could overlap, such as a clear together with a trigger, is applied on purpose in the same cycle, so that the priority stated in R5 and R8 is what the checks see.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

  // Polarity / trigger-kind code carried per pin
  typedef enum logic [1:0] {
    POL_HIGH_RISE = 2'b00,
    POL_LOW_FALL  = 2'b01,
    POL_BOTH      = 2'b10,
    POL_RSVD      = 2'b11
  } pol_e;

  // Sleep state code shared by the bank
  typedef enum logic [1:0] {
    SLP_RUN  = 2'b00,
    SLP_IDLE = 2'b01,
    SLP_RAM  = 2'b10,
    SLP_OFF  = 2'b11
  } sleep_e;

  localparam int WAKE_STATES = 3;

endpackage

// File: rtl/pin_evt_trigger.sv
// Trigger qualifier for one pin: keeps the previous sample and decides
// whether the programmed condition holds this cycle.
module pin_evt_trigger
  import pin_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       level,
  input  logic       lvl_mode,
  input  logic [1:0] pol,
  output logic       hit
);

  logic prev_q;
  logic rise;
  logic fall;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;

  always_comb begin
    hit = 1'b0;
    if (lvl_mode) begin
      unique case (pol_e'(pol))
        POL_HIGH_RISE: hit = level;
        POL_LOW_FALL:  hit = ~level;
        default:       hit = 1'b0;  // both-edges is not valid with level sensing
      endcase
    end else begin
      unique case (pol_e'(pol))
        POL_HIGH_RISE: hit = rise;
        POL_LOW_FALL:  hit = fall;
        POL_BOTH:      hit = rise | fall;
        default:       hit = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/pin_evt_wake_sel.sv
// Picks, for every pin, the wake-enable bit that matches the sleep state.
module pin_evt_wake_sel
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic [1:0]                      sleep_state,
  input  logic [WAKE_STATES*NUM_PINS-1:0] wake_en,
  output logic [NUM_PINS-1:0]             wake_allow
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_comb begin
      unique case (sleep_e'(sleep_state))
        SLP_IDLE: wake_allow[p] = wake_en[WAKE_STATES*p + 0];
        SLP_RAM:  wake_allow[p] = wake_en[WAKE_STATES*p + 1];
        SLP_OFF:  wake_allow[p] = wake_en[WAKE_STATES*p + 2];
        default:  wake_allow[p] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/pin_evt_status.sv
// Sticky status bits for one pin plus the registered qualified outputs.
module pin_evt_status (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic gen_ok,
  input  logic wake_ok,
  input  logic unmask,
  input  logic clr_int,
  input  logic clr_wake,
  output logic int_sts,
  output logic wake_sts,
  output logic pending,
  output logic req,
  output logic en_rb
);

  logic int_d;
  logic wake_d;

  // a clear strobe takes priority over a coincident trigger
  assign int_d  = clr_int  ? 1'b0 : (int_sts  | (hit & gen_ok));
  assign wake_d = clr_wake ? 1'b0 : (wake_sts | (hit & wake_ok));

  always_ff @(posedge clk) begin
    if (rst) begin
      int_sts  <= 1'b0;
      wake_sts <= 1'b0;
      pending  <= 1'b0;
      req      <= 1'b0;
      en_rb    <= 1'b0;
    end else begin
      int_sts  <= int_d;
      wake_sts <= wake_d;
      pending  <= int_d | wake_d;
      req      <= (int_d | wake_d) & gen_ok & unmask;
      en_rb    <= gen_ok;
    end
  end

endmodule

// File: rtl/pin_evt_bank.sv
module pin_evt_bank
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_PINS-1:0]             level_in,
  input  logic [NUM_PINS-1:0]             trig_level,
  input  logic [2*NUM_PINS-1:0]           pol_sel,
  input  logic [NUM_PINS-1:0]             irq_en,
  input  logic [NUM_PINS-1:0]             irq_unmask,
  input  logic [WAKE_STATES*NUM_PINS-1:0] wake_en,
  input  logic [1:0]                      sleep_state,
  input  logic                            block_win,
  input  logic [NUM_PINS-1:0]             clr_int,
  input  logic [NUM_PINS-1:0]             clr_wake,
  output logic [NUM_PINS-1:0]             int_sts,
  output logic [NUM_PINS-1:0]             wake_sts,
  output logic [NUM_PINS-1:0]             pending,
  output logic [NUM_PINS-1:0]             irq_req,
  output logic [NUM_PINS-1:0]             en_readback
);

  logic [NUM_PINS-1:0] wake_allow;
  logic [NUM_PINS-1:0] hit;

  pin_evt_wake_sel #(.NUM_PINS(NUM_PINS)) u_wake_sel (
    .sleep_state (sleep_state),
    .wake_en     (wake_en),
    .wake_allow  (wake_allow)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pin_evt_trigger u_trig (
      .clk      (clk),
      .rst      (rst),
      .level    (level_in[p]),
      .lvl_mode (trig_level[p]),
      .pol      (pol_sel[2*p +: 2]),
      .hit      (hit[p])
    );

    pin_evt_status u_sts (
      .clk      (clk),
      .rst      (rst),
      .hit      (hit[p]),
      .gen_ok   (irq_en[p] & ~block_win),
      .wake_ok  (wake_allow[p] & ~block_win),
      .unmask   (irq_unmask[p]),
      .clr_int  (clr_int[p]),
      .clr_wake (clr_wake[p]),
      .int_sts  (int_sts[p]),
      .wake_sts (wake_sts[p]),
      .pending  (pending[p]),
      .req      (irq_req[p]),
      .en_rb    (en_readback[p])
    );
  end

endmodule

// File: rtl/pin_evt_bank_chk.sv
module pin_evt_bank_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] irq_en,
  input logic [1:0]          sleep_state,
  input logic                block_win,
  input logic [NUM_PINS-1:0] clr_int,
  input logic [NUM_PINS-1:0] clr_wake,
  input logic [NUM_PINS-1:0] int_sts,
  input logic [NUM_PINS-1:0] wake_sts,
  input logic [NUM_PINS-1:0] pending,
  input logic [NUM_PINS-1:0] irq_req,
  input logic [NUM_PINS-1:0] en_readback
);

  a_r5_int_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_int != '0) |=> ((int_sts & $past(clr_int)) == '0));

  a_r8_wake_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_wake != '0) |=> ((wake_sts & $past(clr_wake)) == '0));

  a_r6_no_int_when_off: assert property (@(posedge clk) disable iff (rst)
    (irq_en != '1) |=> ((int_sts & ~$past(int_sts) & ~$past(irq_en)) == '0));

  a_r7_no_wake_running: assert property (@(posedge clk) disable iff (rst)
    (sleep_state == 2'b00) |=> ((wake_sts & ~$past(wake_sts)) == '0));

  a_r9_pending_union: assert property (@(posedge clk) disable iff (rst)
    pending == (int_sts | wake_sts));

  a_r9_req_needs_pending: assert property (@(posedge clk) disable iff (rst)
    (irq_req & ~pending) == '0);

  a_r10_no_new_status: assert property (@(posedge clk) disable iff (rst)
    block_win |=> (((int_sts & ~$past(int_sts)) == '0) &&
                   ((wake_sts & ~$past(wake_sts)) == '0)));

  a_r10_enable_hidden: assert property (@(posedge clk) disable iff (rst)
    block_win |=> ((en_readback == '0) && (irq_req == '0)));

endmodule

bind pin_evt_bank pin_evt_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .irq_en      (irq_en),
  .sleep_state (sleep_state),
  .block_win   (block_win),
  .clr_int     (clr_int),
  .clr_wake    (clr_wake),
  .int_sts     (int_sts),
  .wake_sts    (wake_sts),
  .pending     (pending),
  .irq_req     (irq_req),
  .en_readback (en_readback)
);

// File: tb/pin_evt_bank_test.sv
module pin_evt_bank_test;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]   level_in = '0, trig_level = '0, irq_en = '0, irq_unmask = '0;
  logic [2*N-1:0] pol_sel = '0;
  logic [3*N-1:0] wake_en = '0;
  logic [1:0]     sleep_state = 2'b00;
  logic           block_win = 1'b0;
  logic [N-1:0]   clr_int = '0, clr_wake = '0;
  logic [N-1:0]   int_sts, wake_sts, pending, irq_req, en_readback;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pin_evt_bank #(.NUM_PINS(N)) uut (
    .clk(clk), .rst(rst), .level_in(level_in), .trig_level(trig_level),
    .pol_sel(pol_sel), .irq_en(irq_en), .irq_unmask(irq_unmask),
    .wake_en(wake_en), .sleep_state(sleep_state), .block_win(block_win),
    .clr_int(clr_int), .clr_wake(clr_wake), .int_sts(int_sts),
    .wake_sts(wake_sts), .pending(pending), .irq_req(irq_req),
    .en_readback(en_readback)
  );

  typedef struct packed {
    logic       lvl, trig;
    logic [1:0] pol;
    logic       en, unm;
    logic [2:0] wen;
    logic [1:0] slp;
    logic       blk, ci, cw;
    logic       e_int, e_wake, e_req, e_en;
  } row_t;

  localparam int ROWS = 38;
  localparam row_t TBL [ROWS] = '{
    //lvl trig pol   en unm wen   slp   blk ci cw | int wake req en
    '{1'b0,1'b0,2'd0,1'b1,1'b1,3'd0,2'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1}, // 0  R2 idle
    '{1'b1,1'b0,2'd0,1'b1,1'b1,3'd0,2'd0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1}, // 1  R2 rise
    '{1'b1,1'b0,2'd0,1'b1,1'b1,3'd0,2'd0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1}, // 2  R5 clear
    '{1'b1,1'b0,2'd0,1'b1,1'b1,3'd0,2'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1}, // 3  R2 steady high
    '{1'b0,1'b0,2'd1,1'b1,1'b0,3'd0,2'd0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b1}, // 4  R2 fall, masked
    '{1'b0,1'b0,2'd1,1'b1,1'b1,3'd0,2'd0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1}, // 5  R9 unmask
    '{1'b0,1'b0,2'd1,1'b1,1'b1,3'd0,2'd0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1}, // 6  R5
    '{1'b1,1'b1,2'd0,1'b1,1'b1,3'd0,2'd0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1}, // 7  R4 level high
    '{1'b1,1'b1,2'd0,1'b1,1'b1,3'd0,2'd0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1}, // 8  R5 clear wins
    '{1'b1,1'b1,2'd0,1'b1,1'b1,3'd0,2'd0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1}, // 9  R4 re-assert
    '{1'b0,1'b1,2'd0,1'b1,1'b1,3'd0,2'd0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1}, // 10 R4
    '{1'b0,1'b1,2'd1,1'b1,1'b1,3'd0,2'd0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1}, // 11 R4 level low
    '{1'b1,1'b1,2'd1,1'b1,1'b1,3'd0,2'd0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1}, // 12 R4
    '{1'b0,1'b0,2'd2,1'b1,1'b1,3'd0,2'd0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1}, // 13 R3 both, fall
    '{1'b0,1'b0,2'd2,1'b1,1'b1,3'd0,2'd0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1}, // 14 R3
    '{1'b1,1'b0,2'd2,1'b1,1'b1,3'd0,2'd0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1}, // 15 R3 both, rise
    '{1'b1,1'b0,2'd2,1'b1,1'b1,3'd0,2'd0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1}, // 16 R3
    '{1'b1,1'b1,2'd2,1'b1,1'b1,3'd0,2'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1}, // 17 R3 illegal in level
    '{1'b0,1'b0,2'd0,1'b0,1'b1,3'd0,2'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0}, // 18 R6
    '{1'b1,1'b0,2'd0,1'b0,1'b1,3'd0,2'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0}, // 19 R6 edge while off
    '{1'b1,1'b0,2'd0,1'b1,1'b1,3'd0,2'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1}, // 20 R6 not recorded
    '{1'b0,1'b0,2'd1,1'b1,1'b1,3'd0,2'd0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0}, // 21 R10 blocked
    '{1'b0,1'b0,2'd1,1'b1,1'b1,3'd0,2'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1}, // 22 R10 reopened
    '{1'b1,1'b0,2'd0,1'b0,1'b1,3'd1,2'd1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0}, // 23 R7 idle wake
    '{1'b1,1'b0,2'd0,1'b0,1'b1,3'd1,2'd1,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0}, // 24 R8 clear
    '{1'b0,1'b0,2'd0,1'b0,1'b1,3'd1,2'd1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0}, // 25 R7
    '{1'b1,1'b0,2'd0,1'b0,1'b1,3'd1,2'd2,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0}, // 26 R7 wrong state bit
    '{1'b0,1'b0,2'd0,1'b0,1'b1,3'd1,2'd2,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0}, // 27 R7
    '{1'b1,1'b0,2'd0,1'b1,1'b1,3'd2,2'd2,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b1}, // 28 R7 RAM wake + int
    '{1'b1,1'b0,2'd0,1'b1,1'b1,3'd2,2'd2,1'b0,1'b1,1'b0, 1'b0,1'b1,1'b1,1'b1}, // 29 R9 pending via wake
    '{1'b1,1'b0,2'd0,1'b1,1'b1,3'd2,2'd2,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b1}, // 30 R8
    '{1'b0,1'b0,2'd0,1'b0,1'b1,3'd7,2'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0}, // 31 R7
    '{1'b1,1'b0,2'd0,1'b0,1'b1,3'd7,2'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0}, // 32 R7 running
    '{1'b0,1'b0,2'd0,1'b0,1'b1,3'd4,2'd3,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0}, // 33 R7
    '{1'b1,1'b0,2'd0,1'b0,1'b1,3'd4,2'd3,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0}, // 34 R7 hibernate
    '{1'b1,1'b0,2'd0,1'b0,1'b1,3'd4,2'd3,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0}, // 35 R8
    '{1'b0,1'b0,2'd0,1'b0,1'b1,3'd4,2'd3,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0}, // 36 R7
    '{1'b1,1'b0,2'd0,1'b0,1'b1,3'd4,2'd3,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0}  // 37 R10 blocks wake
  };

  function automatic string row_req(int r);
    if (r == 2 || r == 6 || r == 8) return "R5";
    if (r <= 6)  return "R2";
    if (r <= 12) return "R4";
    if (r <= 17) return "R3";
    if (r <= 20) return "R6";
    if (r <= 22 || r == 37) return "R10";
    if (r == 29) return "R9";
    if (r == 24 || r == 30 || r == 35) return "R8";
    return "R7";
  endfunction

  task automatic check_vec(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req, logic [N-1:0] ei, logic [N-1:0] ew,
                           logic [N-1:0] er, logic [N-1:0] ee);
    check_vec(req, "int_sts", int_sts, ei);
    check_vec(req, "wake_sts", wake_sts, ew);
    check_vec(req, "pending", pending, ei | ew);
    check_vec(req, "irq_req", irq_req, er);
    check_vec(req, "en_readback", en_readback, ee);
  endtask

  // drive on the falling edge, check mid-cycle after the next rising edge
  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state with a high input on every pin
    level_in = '1;
    irq_en = '1;
    irq_unmask = '1;
    repeat (3) @(posedge clk);
    #5;
    check_all("R1", '0, '0, '0, '0);
    @(negedge clk);
    rst = 1'b0;
    tick();  // R1: prev sample was 0 at release, so the high level reads as a rising edge
    check_all("R1", '1, '0, '1, '1);

    // return to a clean state for the table walk
    @(negedge clk);
    rst = 1'b1;
    level_in = '0;
    irq_en = '0;
    irq_unmask = '0;
    tick();
    @(negedge clk);
    rst = 1'b0;

    // table walk on pin 0, others idle
    for (int r = 0; r < ROWS; r++) begin
      level_in    = {{(N-1){1'b0}}, TBL[r].lvl};
      trig_level  = {{(N-1){1'b0}}, TBL[r].trig};
      pol_sel     = {{(2*N-2){1'b0}}, TBL[r].pol};
      irq_en      = {{(N-1){1'b0}}, TBL[r].en};
      irq_unmask  = {{(N-1){1'b0}}, TBL[r].unm};
      wake_en     = {{(3*N-3){1'b0}}, TBL[r].wen};
      sleep_state = TBL[r].slp;
      block_win   = TBL[r].blk;
      clr_int     = {{(N-1){1'b0}}, TBL[r].ci};
      clr_wake    = {{(N-1){1'b0}}, TBL[r].cw};
      tick();
      check_all(row_req(r), {{(N-1){1'b0}}, TBL[r].e_int}, {{(N-1){1'b0}}, TBL[r].e_wake},
                {{(N-1){1'b0}}, TBL[r].e_req}, {{(N-1){1'b0}}, TBL[r].e_en});
      @(negedge clk);
    end

    // R11: independent pins, all rising-edge sensing
    clr_int = '0; clr_wake = '0; block_win = 1'b0; sleep_state = 2'b00;
    wake_en = '0; trig_level = '0; pol_sel = '0;
    irq_en = '1; irq_unmask = 4'b0011; level_in = '0;
    tick();
    @(negedge clk);
    level_in = 4'b1010;
    tick();
    check_all("R11", 4'b1010, '0, 4'b0010, '1);
    @(negedge clk);
    clr_int = 4'b0010;
    tick();
    check_all("R11", 4'b1000, '0, '0, '1);
    @(negedge clk);
    clr_int = '0;
    level_in = 4'b1011;  // only pin 0 rises
    tick();
    check_all("R11", 4'b1001, '0, 4'b0001, '1);

    // R9: block window hides requests of already pending pins
    @(negedge clk);
    block_win = 1'b1;
    tick();
    check_all("R9", 4'b1001, '0, '0, '0);
    @(negedge clk);
    block_win = 1'b0;
    tick();
    check_all("R9", 4'b1001, '0, 4'b0001, '1);

    // R1: reset mid-run clears stored status
    @(negedge clk);
    rst = 1'b1;
    tick();
    check_all("R1", '0, '0, '0, '0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule